// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block listens passively to a four-wire SPI link running between a host and a network-controller peripheral. It never drives the bus. Every chip-select frame is cut into bytes. The first byte of a frame is the command header, and the monitor splits it into a 3-bit operation code and a 5-bit register address. Once the frame ends, the monitor checks the frame length and header against the rules for that operation. It then emits one result: operation code, address, register bank, a data byte, the byte count and a set of error flags.

The peripheral arranges its registers in four banks. The monitor keeps a shadow of the 2-bit bank selector. It updates this shadow from the writes, bit-set and bit-clear commands aimed at the bank-control register, and from system-reset commands. The shadow has two uses: it labels each register access with its bank, and it tells the monitor whether a control read should carry a dummy byte. Until the bank is known, the checks that depend on the bank are skipped.

The bus is sampled through a synchroniser from a system clock that runs at least four times faster than SCK. The monitor assumes SPI mode 0: it samples on the rising SCK edge, MSB first.

Top module: `spi_cmd_monitor`

## Requirements
- R1: Each chip-select frame (spi_cs_n low, then high) that carries at least one complete byte produces exactly one `frame_valid` pulse, one clock long. A frame with no complete byte produces no pulse, and neither does a rise of spi_cs_n outside a frame.
- R2: `cmd_code` is header bits 7:5 and `reg_addr` is header bits 4:0. `byte_count` is the number of complete bytes in the frame. Bytes are sampled MSB first on rising SCK. The codes are 000 control read, 001 buffer read, 010 control write, 011 buffer write, 100 bit set, 101 bit clear and 111 system reset.
- R3: Code 110 sets `err_unknown_op` and no other error flag.
- R4: A buffer read must have header 0x3A and a buffer write must have header 0x7A. Any other header with those codes sets `err_bad_header`. Buffer frames of any length are accepted. The data byte is byte 1, taken from MISO for a read and from MOSI for a write.
- R5: A control write, bit set or bit clear must be 2 bytes long. A system reset must be 1 byte. A control read must be 2 or 3 bytes. Any other length sets `err_bad_length`, and such a frame changes no bank state.
- R6: A correctly sized control write to address 0x1F loads bank bits {1,0} from data bits 1:0, and both bits become known.
- R7: A bit set to 0x1F forces to 1 each bank bit whose mask bit (data bits 1:0) is 1. A bit clear to 0x1F forces those bits to 0. Either command makes those bits known. A system reset clears both bits and makes both known.
- R8: After reset, `bank_known` is 0 and `reg_bank` is 0. `bank_known` rises only once both bank bits are known. While it is low, the dummy-byte check and the reserved check are skipped.
- R9: With the bank known, a control read of a MAC/MII-class register must be 3 bytes, and any other register 2 bytes. A mismatch sets `err_dummy`. The MAC/MII class is bank 2 at 0x00, 0x02-0x04, 0x06-0x0B, 0x12, 0x14 and 0x16-0x19, and bank 3 at 0x00-0x05 and 0x0A.
- R10: With the bank known, a correctly sized control read, control write, bit set or bit clear to a reserved address sets `err_reserved`. The reserved addresses are: bank 0 at 0x18-0x1A; bank 1 at 0x12, 0x13, 0x16, 0x17 and 0x1A; bank 2 at 0x01, 0x05, 0x0C-0x11, 0x13, 0x15 and 0x1A; bank 3 at 0x0B-0x11, 0x13, 0x14, 0x16 and 0x1A.
- R11: For a control read, the data byte is the MISO byte at index 2 in a 3-byte frame and at index 1 otherwise. For a control write, bit set or bit clear, it is MOSI byte 1.
- R12: All result outputs hold their values between `frame_valid` pulses. `reg_bank` and `bank_known` give the bank state in effect before the frame's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Observed serial clock |
| spi_mosi | input | 1 | Observed host-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-host data |
| spi_cs_n | input | 1 | Observed active-low chip select |
| frame_valid | output | 1 | One-cycle pulse when a result is updated |
| cmd_code | output | 3 | Operation code from the header |
| reg_addr | output | 5 | Register address from the header |
| reg_bank | output | 2 | Shadow bank in effect for the frame |
| bank_known | output | 1 | Both bank bits were established |
| data_byte | output | 8 | Selected data byte of the frame |
| byte_count | output | CNT_W | Complete bytes in the frame (saturating) |
| err_unknown_op | output | 1 | Code 110 seen |
| err_bad_header | output | 1 | Buffer header not the exact value |
| err_bad_length | output | 1 | Frame length illegal for the code |
| err_dummy | output | 1 | Dummy-byte presence mismatch |
| err_reserved | output | 1 | Reserved register accessed |

## Verification
The assertions assume a reset at time zero, and they assume that spi_cs_n never falls again within a few system clocks of rising, so that two results cannot fall on adjacent cycles. The bench drives SCK with four system clocks per phase. It changes MOSI and MISO only while SCK is low and holds CS high for several clocks between frames, which keeps every edge inside the synchroniser's capture window. It exercises the unknown-bank state first and then walks the shadow through partial and full knowledge.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
   localparam int BYTE_W = 8;
   localparam int OP_W   = 3;
   localparam int ADDR_W = 5;
   localparam int BANK_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_RD_CTRL = 3'b000,
      OP_RD_BUF  = 3'b001,
      OP_WR_CTRL = 3'b010,
      OP_WR_BUF  = 3'b011,
      OP_BIT_SET = 3'b100,
      OP_BIT_CLR = 3'b101,
      OP_UNUSED  = 3'b110,
      OP_SYS_RST = 3'b111
   } opcode_e;

   localparam logic [BYTE_W-1:0] HDR_RD_BUF = 8'h3A;
   localparam logic [BYTE_W-1:0] HDR_WR_BUF = 8'h7A;
   localparam logic [ADDR_W-1:0] BANK_REG   = 5'h1F;

   typedef struct packed {
      logic [OP_W-1:0]   code;
      logic [ADDR_W-1:0] addr;
      logic [BYTE_W-1:0] data;
      logic              e_unknown;
      logic              e_header;
      logic              e_length;
      logic              e_dummy;
      logic              e_reserved;
   } frame_result_t;

   typedef struct packed {
      logic              load;
      logic              set;
      logic              clr;
      logic              rst;
      logic [BANK_W-1:0] mask;
   } bank_req_t;

   function automatic logic is_mac_class(input logic [BANK_W-1:0] bank,
                                         input logic [ADDR_W-1:0] addr);
      case (bank)
         2'd2:    return addr inside {5'h00, [5'h02:5'h04], [5'h06:5'h0B],
                                      5'h12, 5'h14, [5'h16:5'h19]};
         2'd3:    return addr inside {[5'h00:5'h05], 5'h0A};
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_reserved(input logic [BANK_W-1:0] bank,
                                        input logic [ADDR_W-1:0] addr);
      case (bank)
         2'd0:    return addr inside {[5'h18:5'h1A]};
         2'd1:    return addr inside {5'h12, 5'h13, 5'h16, 5'h17, 5'h1A};
         2'd2:    return addr inside {5'h01, 5'h05, [5'h0C:5'h11], 5'h13,
                                      5'h15, 5'h1A};
         default: return addr inside {[5'h0B:5'h11], 5'h13, 5'h14, 5'h16,
                                      5'h1A};
      endcase
   endfunction
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_mon_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_mon_sync width must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe[s] <= RST_VAL;
            end else if (s == 0) begin
               pipe[s] <= d;
            end else begin
               pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mon_framer.sv
module spi_mon_framer
   import spi_mon_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              miso_s,
   input  logic              cs_n_s,
   output logic              frame_end,
   output logic [BYTE_W-1:0] header_q,
   output logic [BYTE_W-1:0] mosi1_q,
   output logic [BYTE_W-1:0] miso1_q,
   output logic [BYTE_W-1:0] miso2_q,
   output logic [CNT_W-1:0]  byte_cnt_q
);
   localparam int               BIT_W   = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BYTE_W-1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("spi_mon_framer count width must be at least 2");
      end
   endgenerate

   logic              sck_d, cs_d, active_q;
   logic [BIT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] mo_sr, mi_sr;
   logic              sck_rise, cs_fall, cs_rise, shift_en, byte_done;
   logic [BYTE_W-1:0] mo_full, mi_full;

   assign sck_rise  = sck_s & ~sck_d;
   assign cs_fall   = ~cs_n_s & cs_d;
   assign cs_rise   = cs_n_s & ~cs_d;
   assign shift_en  = active_q & ~cs_n_s & sck_rise;
   assign byte_done = shift_en & (bit_q == BIT_END);
   assign mo_full   = {mo_sr[BYTE_W-2:0], mosi_s};
   assign mi_full   = {mi_sr[BYTE_W-2:0], miso_s};
   assign frame_end = cs_rise & active_q & (byte_cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (cs_fall) begin
         active_q <= 1'b1;
      end else if (cs_rise) begin
         active_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
         mo_sr <= '0;
         mi_sr <= '0;
      end else if (cs_fall) begin
         bit_q <= '0;
         mo_sr <= '0;
         mi_sr <= '0;
      end else if (shift_en) begin
         bit_q <= bit_q + 1'b1;
         mo_sr <= mo_full;
         mi_sr <= mi_full;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt_q <= '0;
         header_q   <= '0;
         mosi1_q    <= '0;
         miso1_q    <= '0;
         miso2_q    <= '0;
      end else if (cs_fall) begin
         byte_cnt_q <= '0;
         header_q   <= '0;
         mosi1_q    <= '0;
         miso1_q    <= '0;
         miso2_q    <= '0;
      end else if (byte_done) begin
         if (byte_cnt_q != CNT_MAX) begin
            byte_cnt_q <= byte_cnt_q + 1'b1;
         end
         if (byte_cnt_q == CNT_W'(0)) begin
            header_q <= mo_full;
         end
         if (byte_cnt_q == CNT_W'(1)) begin
            mosi1_q <= mo_full;
            miso1_q <= mi_full;
         end
         if (byte_cnt_q == CNT_W'(2)) begin
            miso2_q <= mi_full;
         end
      end
   end

   // R2: the count moves only by one step or back to zero
   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_cnt_q != $past(byte_cnt_q)) |->
         ((byte_cnt_q == $past(byte_cnt_q) + 1'b1) || (byte_cnt_q == '0)));

   // R1: no frame end is reported without a frame in progress
   assert_end_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !active_q);
endmodule

// File: rtl/spi_mon_decode.sv
module spi_mon_decode
   import spi_mon_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [BYTE_W-1:0] header,
   input  logic [BYTE_W-1:0] mosi1,
   input  logic [BYTE_W-1:0] miso1,
   input  logic [BYTE_W-1:0] miso2,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [BANK_W-1:0] bank,
   input  logic              bank_known,
   output frame_result_t     result,
   output bank_req_t         bank_req
);
   localparam logic [CNT_W-1:0] LEN1 = CNT_W'(1);
   localparam logic [CNT_W-1:0] LEN2 = CNT_W'(2);
   localparam logic [CNT_W-1:0] LEN3 = CNT_W'(3);

   opcode_e           op;
   logic [ADDR_W-1:0] addr;
   logic              reg_access, mac_reg, rsv_reg, to_bank_reg;

   assign op          = opcode_e'(header[BYTE_W-1 -: OP_W]);
   assign addr        = header[ADDR_W-1:0];
   assign mac_reg     = is_mac_class(bank, addr);
   assign rsv_reg     = is_reserved(bank, addr);
   assign to_bank_reg = (addr == BANK_REG);

   always_comb begin
      result            = '0;
      bank_req          = '0;
      reg_access        = 1'b0;
      result.code       = header[BYTE_W-1 -: OP_W];
      result.addr       = addr;
      bank_req.mask     = mosi1[BANK_W-1:0];
      unique case (op)
         OP_RD_CTRL: begin
            if ((byte_cnt == LEN2) || (byte_cnt == LEN3)) begin
               reg_access     = 1'b1;
               result.data    = (byte_cnt == LEN3) ? miso2 : miso1;
               result.e_dummy = bank_known & (mac_reg != (byte_cnt == LEN3));
            end else begin
               result.e_length = 1'b1;
            end
         end
         OP_RD_BUF: begin
            if (header != HDR_RD_BUF) result.e_header = 1'b1;
            else                      result.data     = miso1;
         end
         OP_WR_BUF: begin
            if (header != HDR_WR_BUF) result.e_header = 1'b1;
            else                      result.data     = mosi1;
         end
         OP_WR_CTRL, OP_BIT_SET, OP_BIT_CLR: begin
            if (byte_cnt == LEN2) begin
               reg_access   = 1'b1;
               result.data  = mosi1;
               bank_req.load = to_bank_reg & (op == OP_WR_CTRL);
               bank_req.set  = to_bank_reg & (op == OP_BIT_SET);
               bank_req.clr  = to_bank_reg & (op == OP_BIT_CLR);
            end else begin
               result.e_length = 1'b1;
            end
         end
         OP_SYS_RST: begin
            if (byte_cnt == LEN1) bank_req.rst     = 1'b1;
            else                  result.e_length = 1'b1;
         end
         default: begin
            result.e_unknown = 1'b1;
         end
      endcase
      result.e_reserved = reg_access & bank_known & rsv_reg;
   end
endmodule

// File: rtl/spi_mon_bank.sv
module spi_mon_bank
   import spi_mon_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  bank_req_t         req,
   output logic [BANK_W-1:0] bank_q,
   output logic [BANK_W-1:0] known_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         known_q <= '0;
      end else if (apply) begin
         if (req.rst) begin
            bank_q  <= '0;
            known_q <= '1;
         end else if (req.load) begin
            bank_q  <= req.mask;
            known_q <= '1;
         end else if (req.set) begin
            bank_q  <= bank_q | req.mask;
            known_q <= known_q | req.mask;
         end else if (req.clr) begin
            bank_q  <= bank_q & ~req.mask;
            known_q <= known_q | req.mask;
         end
      end
   end

   // R7: a system reset leaves the bank at zero and fully known
   assert_rst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && req.rst) |=> ((bank_q == '0) && (known_q == '1)));

   // R8: knowledge of a bank bit is never lost
   assert_known_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(known_q) & ~known_q) == '0));

   // R5: without an apply strobe the shadow does not move
   assert_hold_no_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(apply) |-> ($stable(bank_q) && $stable(known_q)));
endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
   import spi_mon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_miso,
   input  logic              spi_cs_n,
   output logic              frame_valid,
   output logic [OP_W-1:0]   cmd_code,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BANK_W-1:0] reg_bank,
   output logic              bank_known,
   output logic [BYTE_W-1:0] data_byte,
   output logic [CNT_W-1:0]  byte_count,
   output logic              err_unknown_op,
   output logic              err_bad_header,
   output logic              err_bad_length,
   output logic              err_dummy,
   output logic              err_reserved
);
   localparam int NUM_LINES = 4;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_cmd_monitor needs two or more synchroniser stages");
      end
   endgenerate

   logic [NUM_LINES-1:0] lines_s;
   logic                 sck_s, mosi_s, miso_s, cs_n_s;
   logic                 frame_end;
   logic [BYTE_W-1:0]    header, mosi1, miso1, miso2;
   logic [CNT_W-1:0]     cnt;
   logic [BANK_W-1:0]    bank_q, known_q;
   frame_result_t        res;
   bank_req_t            req;

   spi_mon_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1000)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_sck, spi_mosi, spi_miso}),
      .q    (lines_s)
   );

   assign {cs_n_s, sck_s, mosi_s, miso_s} = lines_s;

   spi_mon_framer #(.CNT_W(CNT_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .mosi_s    (mosi_s),
      .miso_s    (miso_s),
      .cs_n_s    (cs_n_s),
      .frame_end (frame_end),
      .header_q  (header),
      .mosi1_q   (mosi1),
      .miso1_q   (miso1),
      .miso2_q   (miso2),
      .byte_cnt_q(cnt)
   );

   spi_mon_decode #(.CNT_W(CNT_W)) u_decode (
      .header    (header),
      .mosi1     (mosi1),
      .miso1     (miso1),
      .miso2     (miso2),
      .byte_cnt  (cnt),
      .bank      (bank_q),
      .bank_known(&known_q),
      .result    (res),
      .bank_req  (req)
   );

   spi_mon_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .apply  (frame_end),
      .req    (req),
      .bank_q (bank_q),
      .known_q(known_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
      end else begin
         frame_valid <= frame_end;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_code       <= '0;
         reg_addr       <= '0;
         reg_bank       <= '0;
         bank_known     <= 1'b0;
         data_byte      <= '0;
         byte_count     <= '0;
         err_unknown_op <= 1'b0;
         err_bad_header <= 1'b0;
         err_bad_length <= 1'b0;
         err_dummy      <= 1'b0;
         err_reserved   <= 1'b0;
      end else if (frame_end) begin
         cmd_code       <= res.code;
         reg_addr       <= res.addr;
         reg_bank       <= bank_q;
         bank_known     <= &known_q;
         data_byte      <= res.data;
         byte_count     <= cnt;
         err_unknown_op <= res.e_unknown;
         err_bad_header <= res.e_header;
         err_bad_length <= res.e_length;
         err_dummy      <= res.e_dummy;
         err_reserved   <= res.e_reserved;
      end
   end

   // R1: the result strobe is a single cycle
   assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R3: an unknown code carries no other error
   assert_unknown_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && err_unknown_op) |->
         !(err_bad_header || err_bad_length || err_dummy || err_reserved));

   // R4: header errors only belong to buffer codes
   assert_header_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && err_bad_header) |-> (cmd_code[OP_W-1] == 1'b0 && cmd_code[0]));

   // R9: a dummy-byte error needs a known bank and a legal read length
   assert_dummy_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && err_dummy) |-> (bank_known && !err_bad_length));

   // R12: results only change alongside the strobe
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> ($stable(reg_addr) && $stable(data_byte) && $stable(reg_bank)));
endmodule

// File: tb/spi_cmd_monitor_bench.sv
module spi_cmd_monitor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, mosi = 1'b0, miso = 1'b0, cs_n = 1'b1;
   logic       frame_valid, bank_known;
   logic [2:0] cmd_code;
   logic [4:0] reg_addr;
   logic [1:0] reg_bank;
   logic [7:0] data_byte, byte_count;
   logic       e_unk, e_hdr, e_len, e_dum, e_rsv;

   int checks = 0;
   int failures = 0;
   int nframes = 0;
   int nf_start = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cmd_monitor u_spi_cmd_monitor (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso), .spi_cs_n(cs_n), .frame_valid(frame_valid),
      .cmd_code(cmd_code), .reg_addr(reg_addr), .reg_bank(reg_bank),
      .bank_known(bank_known), .data_byte(data_byte), .byte_count(byte_count),
      .err_unknown_op(e_unk), .err_bad_header(e_hdr), .err_bad_length(e_len),
      .err_dummy(e_dum), .err_reserved(e_rsv)
   );

   always @(posedge clk) if (frame_valid) nframes <= nframes + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input int n, input logic [63:0] mo, input logic [63:0] mi);
      nf_start = nframes;
      @(negedge clk) cs_n = 1'b0;
      for (int b = 0; b < n; b++) begin
         for (int i = 7; i >= 0; i--) begin
            mosi = mo[56-8*b+i];
            miso = mi[56-8*b+i];
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0;
         end
      end
      repeat (HALF_SCK) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input int code, input int addr,
                               input int bank, input int known, input int data,
                               input int cnt, input logic [4:0] errs);
      chk(req, "frame pulses", nframes - nf_start, 1);
      chk(req, "cmd_code", cmd_code, code);
      chk(req, "reg_addr", reg_addr, addr);
      chk(req, "reg_bank", reg_bank, bank);
      chk(req, "bank_known", bank_known, known);
      chk(req, "data_byte", data_byte, data);
      chk(req, "byte_count", byte_count, cnt);
      chk(req, "errors", {e_unk, e_hdr, e_len, e_dum, e_rsv}, errs);
   endtask

   // Buffer-read probe: reports the bank state without changing it
   task automatic probe_bank(input string req, input int bank, input int known);
      send_frame(2, {8'h3A, 8'h00, 48'h0}, 64'h0);
      expect_frame(req, 1, 5'h1A, bank, known, 0, 2, 5'b00000);
   endtask

   task automatic test_reset;
      chk("R8", "frame_valid at reset", frame_valid, 0);
      chk("R8", "bank_known at reset", bank_known, 0);
      chk("R8", "reg_bank at reset", reg_bank, 0);
      chk("R8", "errors at reset", {e_unk, e_hdr, e_len, e_dum, e_rsv}, 0);
   endtask

   task automatic test_empty_frames;
      nf_start = nframes;
      @(negedge clk) cs_n = 1'b0;
      repeat (20) @(negedge clk);
      cs_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1", "zero-byte frame pulses", nframes - nf_start, 0);
      // partial byte only: three bits then CS high
      @(negedge clk) cs_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         repeat (HALF_SCK) @(negedge clk);
         sck = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF_SCK) @(negedge clk);
      cs_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1", "partial-byte frame pulses", nframes - nf_start, 0);
   endtask

   task automatic test_unknown_op;
      send_frame(2, {8'hC5, 8'h00, 48'h0}, 64'h0);
      expect_frame("R3", 6, 5'h05, 0, 0, 0, 2, 5'b10000);
   endtask

   task automatic test_read_unknown_bank;
      // R8 / R11: no dummy check while bank unknown, data from third MISO byte
      send_frame(3, 64'h0, {8'h00, 8'hAA, 8'h5B, 40'h0});
      expect_frame("R8", 0, 5'h00, 0, 0, 8'h5B, 3, 5'b00000);
      send_frame(2, {8'h18, 8'h00, 48'h0}, {8'h00, 8'hC4, 48'h0});
      expect_frame("R11", 0, 5'h18, 0, 0, 8'hC4, 2, 5'b00000);
   endtask

   task automatic test_buffer;
      send_frame(3, 64'h3A00_0000_0000_0000, 64'h0011_2200_0000_0000);
      expect_frame("R4", 1, 5'h1A, 0, 0, 8'h11, 3, 5'b00000);
      send_frame(2, 64'h3B00_0000_0000_0000, 64'h0011_0000_0000_0000);
      expect_frame("R4", 1, 5'h1B, 0, 0, 0, 2, 5'b01000);
      send_frame(4, 64'h7AC3_5566_0000_0000, 64'h0);
      expect_frame("R4", 3, 5'h1A, 0, 0, 8'hC3, 4, 5'b00000);
      send_frame(1, 64'h7A00_0000_0000_0000, 64'h0);
      expect_frame("R4", 3, 5'h1A, 0, 0, 0, 1, 5'b00000);
      send_frame(2, 64'h6A55_0000_0000_0000, 64'h0);
      expect_frame("R4", 3, 5'h0A, 0, 0, 0, 2, 5'b01000);
   endtask

   task automatic test_lengths;
      send_frame(3, 64'h4112_3400_0000_0000, 64'h0);
      expect_frame("R5", 2, 5'h01, 0, 0, 0, 3, 5'b00100);
      send_frame(2, 64'hFF00_0000_0000_0000, 64'h0);
      expect_frame("R5", 7, 5'h1F, 0, 0, 0, 2, 5'b00100);
      send_frame(1, 64'h0000_0000_0000_0000, 64'h0);
      expect_frame("R5", 0, 5'h00, 0, 0, 0, 1, 5'b00100);
      send_frame(4, 64'h0, 64'h0);
      expect_frame("R5", 0, 5'h00, 0, 0, 0, 4, 5'b00100);
      probe_bank("R5", 0, 0);
   endtask

   task automatic test_bitops;
      send_frame(2, 64'h9F01_0000_0000_0000, 64'h0);
      expect_frame("R7", 4, 5'h1F, 0, 0, 8'h01, 2, 5'b00000);
      probe_bank("R7", 1, 0);
      send_frame(2, 64'hBF02_0000_0000_0000, 64'h0);
      expect_frame("R7", 5, 5'h1F, 1, 0, 8'h02, 2, 5'b00000);
      probe_bank("R7", 1, 1);
      send_frame(1, 64'hFF00_0000_0000_0000, 64'h0);
      expect_frame("R7", 7, 5'h1F, 1, 1, 0, 1, 5'b00000);
      probe_bank("R7", 0, 1);
      // bit set to another address leaves the bank alone
      send_frame(2, 64'h9E03_0000_0000_0000, 64'h0);
      probe_bank("R7", 0, 1);
   endtask

   task automatic test_bank_write;
      send_frame(2, 64'h5F03_0000_0000_0000, 64'h0);
      expect_frame("R6", 2, 5'h1F, 0, 1, 8'h03, 2, 5'b00000);
      probe_bank("R6", 3, 1);
      send_frame(2, 64'h5FFE_0000_0000_0000, 64'h0);
      probe_bank("R6", 2, 1);
      send_frame(3, 64'h5F01_0000_0000_0000, 64'h0);
      expect_frame("R5", 2, 5'h1F, 2, 1, 0, 3, 5'b00100);
      probe_bank("R5", 2, 1);
   endtask

   task automatic test_dummy;
      send_frame(2, 64'h0, 64'h0077_0000_0000_0000);
      expect_frame("R9", 0, 5'h00, 2, 1, 8'h77, 2, 5'b00010);
      send_frame(3, 64'h0, 64'h0011_9900_0000_0000);
      expect_frame("R9", 0, 5'h00, 2, 1, 8'h99, 3, 5'b00000);
      send_frame(2, 64'h1D00_0000_0000_0000, 64'h0042_0000_0000_0000);
      expect_frame("R9", 0, 5'h1D, 2, 1, 8'h42, 2, 5'b00000);
      send_frame(3, 64'h1D00_0000_0000_0000, 64'h0000_3300_0000_0000);
      expect_frame("R9", 0, 5'h1D, 2, 1, 8'h33, 3, 5'b00010);
   endtask

   task automatic test_reserved;
      send_frame(2, 64'h0100_0000_0000_0000, 64'h00E1_0000_0000_0000);
      expect_frame("R10", 0, 5'h01, 2, 1, 8'hE1, 2, 5'b00001);
      send_frame(2, 64'h5A10_0000_0000_0000, 64'h0);
      expect_frame("R10", 2, 5'h1A, 2, 1, 8'h10, 2, 5'b00001);
      send_frame(2, 64'hB205_0000_0000_0000, 64'h0);
      expect_frame("R10", 5, 5'h12, 2, 1, 8'h05, 2, 5'b00000);
   endtask

   task automatic test_hold;
      repeat (60) @(negedge clk);
      chk("R12", "reg_addr held", reg_addr, 5'h12);
      chk("R12", "data_byte held", data_byte, 8'h05);
      nf_start = nframes;
      @(negedge clk) cs_n = 1'b0;
      repeat (10) @(negedge clk);
      cs_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R12", "no pulse on empty frame", nframes - nf_start, 0);
      chk("R12", "cmd_code held", cmd_code, 5);
      chk("R12", "byte_count held", byte_count, 2);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      test_reset;
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      test_reset;
      test_empty_frames;
      test_unknown_op;
      test_read_unknown_bank;
      test_buffer;
      test_lengths;
      test_bitops;
      test_bank_write;
      test_dummy;
      test_reserved;
      test_hold;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule